// File: doc/BRIEF.md
# Save EEPROM Size Classifier

This block sorts a cartridge save EEPROM into one of three classes: absent, small (4Kbit) or large (64Kbit). It does this by watching the first 512 bytes read back from the part. The reads use the wide (64Kbit) address framing. When a small part receives wide addresses, it returns its first 8-byte block again and again. A missing part returns only 0x00 or 0xFF. The classifier therefore keeps two tallies:

- Blank bytes seen anywhere in the stream.
- Bytes in later groups that match the byte at the same position in the first group.

A short decision is made from these two tallies once the stream is complete.

The bytes arrive one per valid strobe, as 64 consecutive groups of 8. Gaps between strobes are allowed. A start pulse arms the block, and the serial access that fetches the bytes sits outside it. After the 512th byte, the block raises a done flag and presents a 2-bit class code. Both stay unchanged until the next start pulse.

Top module: `eeprom_size_classifier`

## Requirements
- R1: While reset is asserted and just after it is released, `done_o` is 0 and `class_o` is 2'b00.
- R2: `done_o` rises on the clock edge that accepts the 512th byte and not earlier. Bytes are accepted only when `byte_valid_i` is high and `start_i` is low.
- R3: Once `done_o` is high, further valid bytes have no effect. Both `done_o` and `class_o` keep their values until the next start pulse.
- R4: Bytes of the first 8-byte group are stored as the reference and are never counted as repeats.
- R5: Each byte in groups 1 to 63 that equals the reference byte at the same position (0 to 7) adds one to the repeat tally.
- R6: Each byte equal to 0x00 or 0xFF, in any group including the first, adds one to the blank tally.
- R7: A blank tally of at least 512 gives `class_o` = 2'b00 (absent). This takes priority over the repeat tally.
- R8: If R7 does not apply and the repeat tally is at least 300, `class_o` = 2'b01 (small part).
- R9: If neither threshold is met, `class_o` = 2'b10 (large part). The code 2'b11 never appears.
- R10: A start pulse clears both tallies, the reference and the byte position. On the following edge `done_o` is 0 and `class_o` is 2'b00. A byte presented in the same cycle as the start pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clears the tallies and re-arms for a new 512-byte stream |
| byte_valid_i | input | 1 | Qualifies `byte_i` for one cycle |
| byte_i | input | 8 | Byte read back from the save part |
| class_o | output | 2 | 00 absent, 01 small (4Kbit), 10 large (64Kbit) |
| done_o | output | 1 | High once the full stream has been classified |

## Verification
On every cycle, the embedded assertions check the following:

- The result is held while done is high.
- A start pulse clears the result.
- The reserved class code never appears.
- Completion only follows an accepted final byte.
- The tallies neither wrap nor fall between starts.
- The reference bytes stay frozen outside the first group.

Only the bench's scenarios can show that the tallies produce the right class. These scenarios cover threshold values just above and below each limit, the priority of the blank test, and the exclusion of the first group from repeat counting. They also show that a start pulse mid-stream or alongside a valid byte truly discards earlier data.

// File: rtl/esc_pkg.sv
package esc_pkg;

    typedef enum logic [1:0] {
        SIZE_ABSENT = 2'b00,
        SIZE_SMALL  = 2'b01,
        SIZE_LARGE  = 2'b10
    } size_class_e;

    function automatic logic is_blank_byte(input logic [7:0] b);
        return (b == 8'h00) || (b == 8'hFF);
    endfunction

endpackage

// File: rtl/esc_position_tracker.sv
module esc_position_tracker #(
    parameter int GROUP_BYTES = 8,
    parameter int GROUPS      = 64,
    localparam int POS_W      = (GROUP_BYTES > 1) ? $clog2(GROUP_BYTES) : 1,
    localparam int GRP_W      = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [POS_W-1:0] pos_o,
    output logic             first_group_o,
    output logic             last_byte_o,
    output logic             full_o
);

    localparam logic [POS_W-1:0] POS_LAST = POS_W'(GROUP_BYTES - 1);
    localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(GROUPS - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [GRP_W-1:0] grp;
        logic             full;
    } trk_t;

    trk_t trk_d, trk_q;

    logic pos_wrap;
    assign pos_wrap      = (trk_q.pos == POS_LAST);
    assign last_byte_o   = pos_wrap && (trk_q.grp == GRP_LAST);
    assign first_group_o = (trk_q.grp == '0);
    assign pos_o         = trk_q.pos;
    assign full_o        = trk_q.full;

    always_comb begin
        trk_d = trk_q;
        if (clear_i) begin
            trk_d = '0;
        end else if (step_i && !trk_q.full) begin
            if (pos_wrap) begin
                trk_d.pos = '0;
                if (trk_q.grp == GRP_LAST) begin
                    trk_d.full = 1'b1;
                    trk_d.grp  = '0;
                end else begin
                    trk_d.grp = trk_q.grp + 1'b1;
                end
            end else begin
                trk_d.pos = trk_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    // R2
    full_only_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_o) |-> $past(step_i && last_byte_o && !clear_i));

    // R3
    pos_frozen_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !clear_i) |=> (full_o && $stable(pos_o)));

endmodule

// File: rtl/esc_ref_store.sv
module esc_ref_store #(
    parameter int GROUP_BYTES = 8,
    localparam int POS_W      = (GROUP_BYTES > 1) ? $clog2(GROUP_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             write_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic [7:0]       data_i,
    output logic [7:0]       ref_o
);

    typedef struct packed {
        logic [GROUP_BYTES-1:0][7:0] bytes;
    } ref_t;

    ref_t ref_d, ref_q;

    assign ref_o = ref_q.bytes[pos_i];

    always_comb begin
        ref_d = ref_q;
        if (clear_i) begin
            ref_d = '0;
        end else if (write_i) begin
            ref_d.bytes[pos_i] = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_q <= '0;
        else        ref_q <= ref_d;
    end

    // R4
    ref_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!write_i && !clear_i) |=> $stable(ref_q));

endmodule

// File: rtl/esc_sat_counter.sv
module esc_sat_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    assign count_o = cnt_q.cnt;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d.cnt = '0;
        end else if (inc_i && (cnt_q.cnt != CNT_MAX)) begin
            cnt_d.cnt = cnt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5 R6: tallies only move upward between starts
    no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (count_o >= $past(count_o)));

    // R5 R6: a full tally holds instead of wrapping
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == CNT_MAX && !clear_i) |=> (count_o == CNT_MAX));

endmodule

// File: rtl/eeprom_size_classifier.sv
module eeprom_size_classifier #(
    parameter int GROUP_BYTES = 8,
    parameter int GROUPS      = 64,
    parameter int CNT_W       = 10,
    parameter int BLANK_MIN   = 512,
    parameter int REPEAT_MIN  = 300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       byte_valid_i,
    input  logic [7:0] byte_i,
    output logic [1:0] class_o,
    output logic       done_o
);
    import esc_pkg::*;

    localparam int POS_W = (GROUP_BYTES > 1) ? $clog2(GROUP_BYTES) : 1;
    localparam logic [CNT_W:0] BLANK_LIM  = (CNT_W + 1)'(BLANK_MIN);
    localparam logic [CNT_W:0] REPEAT_LIM = (CNT_W + 1)'(REPEAT_MIN);

    logic [POS_W-1:0] pos;
    logic             first_group;
    logic             last_byte;
    logic             full;
    logic [7:0]       ref_byte;
    logic [CNT_W-1:0] blank_cnt;
    logic [CNT_W-1:0] repeat_cnt;
    logic             accept;
    logic             blank_inc;
    logic             repeat_inc;
    logic [CNT_W:0]   blank_total;
    logic [CNT_W:0]   repeat_total;
    size_class_e      verdict;

    typedef struct packed {
        size_class_e cls;
    } res_t;

    res_t res_d, res_q;

    assign accept     = byte_valid_i && !start_i && !full;
    assign blank_inc  = accept && is_blank_byte(byte_i);
    assign repeat_inc = accept && !first_group && (byte_i == ref_byte);

    esc_position_tracker #(
        .GROUP_BYTES(GROUP_BYTES),
        .GROUPS     (GROUPS)
    ) u_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (start_i),
        .step_i       (accept),
        .pos_o        (pos),
        .first_group_o(first_group),
        .last_byte_o  (last_byte),
        .full_o       (full)
    );

    esc_ref_store #(
        .GROUP_BYTES(GROUP_BYTES)
    ) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(start_i),
        .write_i(accept && first_group),
        .pos_i  (pos),
        .data_i (byte_i),
        .ref_o  (ref_byte)
    );

    esc_sat_counter #(.CNT_W(CNT_W)) u_blank_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(start_i),
        .inc_i  (blank_inc),
        .count_o(blank_cnt)
    );

    esc_sat_counter #(.CNT_W(CNT_W)) u_repeat_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(start_i),
        .inc_i  (repeat_inc),
        .count_o(repeat_cnt)
    );

    // Totals include the byte accepted this cycle so the final byte counts.
    assign blank_total  = {1'b0, blank_cnt}  + {{CNT_W{1'b0}}, blank_inc};
    assign repeat_total = {1'b0, repeat_cnt} + {{CNT_W{1'b0}}, repeat_inc};

    always_comb begin
        if (blank_total >= BLANK_LIM)       verdict = SIZE_ABSENT;
        else if (repeat_total >= REPEAT_LIM) verdict = SIZE_SMALL;
        else                                 verdict = SIZE_LARGE;
    end

    always_comb begin
        res_d = res_q;
        if (start_i) begin
            res_d.cls = SIZE_ABSENT;
        end else if (accept && last_byte) begin
            res_d.cls = verdict;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '{cls: SIZE_ABSENT};
        else        res_q <= res_d;
    end

    assign class_o = res_q.cls;
    assign done_o  = full;

    // R3
    result_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(class_o)));

    // R10
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done_o && class_o == 2'b00));

    // R9
    no_reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        class_o != 2'b11);

    // R2
    class_idle_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !(accept && last_byte)) |=> (class_o == 2'b00));

endmodule

// File: tb/eeprom_size_classifier_tb.sv
`timescale 1ns/1ps
module eeprom_size_classifier_tb;

    localparam int TOTAL = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       vld = 1'b0;
    logic [7:0] din = 8'h00;
    logic [1:0] cls;
    logic       done;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] img [TOTAL];

    always #2 clk = ~clk;

    eeprom_size_classifier u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .byte_valid_i(vld),
        .byte_i      (din),
        .class_o     (cls),
        .done_o      (done)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Model from the requirements: blank tally over all bytes, repeats in groups 1..63.
    function automatic logic [1:0] model_class();
        int blanks = 0;
        int reps = 0;
        for (int i = 0; i < TOTAL; i++) begin
            if (img[i] == 8'h00 || img[i] == 8'hFF) blanks++;
            if (i >= 8 && img[i] == img[i % 8]) reps++;
        end
        if (blanks >= 512) return 2'b00;
        if (reps >= 300)   return 2'b01;
        return 2'b10;
    endfunction

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R10", "done after start", {7'd0, done}, 8'h00);
        check("R10", "class after start", {6'd0, cls}, 8'h00);
    endtask

    task automatic stream(input int gap);
        for (int i = 0; i < TOTAL; i++) begin
            @(negedge clk);
            if (i == TOTAL - 1) check("R2", "done before last byte", {7'd0, done}, 8'h00);
            vld = 1'b1;
            din = img[i];
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                vld = 1'b0;
                din = 8'hA5;
            end
        end
        @(negedge clk);
        vld = 1'b0;
    endtask

    task automatic run_and_check(input string req, input int gap);
        logic [1:0] exp;
        exp = model_class();
        pulse_start();
        stream(gap);
        check("R2", "done after 512 bytes", {7'd0, done}, 8'h01);
        check(req, "class", {6'd0, cls}, {6'd0, exp});
    endtask

    // Later groups: first m bytes match, next b are blank, rest differ and are not blank.
    task automatic fill_split(input int m, input int b);
        for (int p = 0; p < 8; p++) img[p] = 8'h20 + 8'(p);
        for (int k = 0; k < TOTAL - 8; k++) begin
            if (k < m)          img[k + 8] = img[k % 8];
            else if (k < m + b) img[k + 8] = (k % 2 == 0) ? 8'h00 : 8'hFF;
            else                img[k + 8] = 8'h40 + 8'(k % 8);
        end
    endtask

    task automatic t_reset();
        check("R1", "done in reset", {7'd0, done}, 8'h00);
        check("R1", "class in reset", {6'd0, cls}, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1", "done after reset", {7'd0, done}, 8'h00);
        check("R1", "class after reset", {6'd0, cls}, 8'h00);
    endtask

    task automatic t_all_blank();
        for (int i = 0; i < TOTAL; i++) img[i] = (i % 3 == 0) ? 8'hFF : 8'h00;
        run_and_check("R7", 0);
        check("R7", "blank beats repeats", {6'd0, cls}, 8'h00);
    endtask

    task automatic t_blank_511();
        for (int i = 0; i < TOTAL; i++) img[i] = 8'h00;
        img[TOTAL - 1] = 8'h5A;
        run_and_check("R6", 1);
        check("R8", "511 blanks with repeats", {6'd0, cls}, 8'h01);
    endtask

    task automatic t_aliased();
        fill_split(504, 0);
        run_and_check("R5", 0);
        check("R8", "aliased small part", {6'd0, cls}, 8'h01);
    endtask

    task automatic t_distinct();
        for (int i = 0; i < TOTAL; i++) img[i] = 8'((i % 254) + 1);
        run_and_check("R9", 2);
        check("R9", "distinct large part", {6'd0, cls}, 8'h02);
    endtask

    task automatic t_repeat_edges();
        fill_split(300, 100);
        run_and_check("R8", 0);
        check("R8", "repeat exactly 300", {6'd0, cls}, 8'h01);
        fill_split(299, 100);
        run_and_check("R4", 0);
        check("R4", "first group not counted (299)", {6'd0, cls}, 8'h02);
    endtask

    task automatic t_ignore_after_done();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); vld = 1'b1; din = 8'h00;
        end
        @(negedge clk); vld = 1'b0;
        check("R3", "done held", {7'd0, done}, 8'h01);
        check("R3", "class held", {6'd0, cls}, 8'h02);
    endtask

    task automatic t_restart_midstream();
        pulse_start();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); vld = 1'b1; din = 8'hFF;
        end
        @(negedge clk); vld = 1'b1; din = 8'h00; start = 1'b1;
        @(negedge clk); vld = 1'b0; start = 1'b0;
        check("R10", "done cleared mid-stream", {7'd0, done}, 8'h00);
        for (int i = 0; i < TOTAL; i++) img[i] = 8'((i % 254) + 1);
        stream(0);
        check("R10", "done after fresh stream", {7'd0, done}, 8'h01);
        check("R10", "stale bytes discarded", {6'd0, cls}, 8'h02);
    endtask

    initial begin
        t_reset();
        t_all_blank();
        t_blank_511();
        t_aliased();
        t_distinct();
        t_ignore_after_done();
        t_repeat_edges();
        t_restart_midstream();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule